// File: doc/BRIEF.md
# Shared-Level Interrupt Funnel

This block merges eleven active-low interrupt request lines from on-board peripherals into one level-sensitive interrupt request for an 8-bit processor. Each request line first passes through a two-flop synchronizer. Five of the lines can be enabled or disabled by software. The other six always reach the processor. The request output is the OR of every enabled, synchronized request.

When the processor acknowledges an interrupt, the block drives a single-byte restart opcode (0xFF) onto the data bus. This sends execution to the fixed entry at address 0x38. Every source shares this one entry. The service routine therefore reads a status view of all eleven synchronized requests to find which source is asking. Acknowledge does not clear any source: the request output stays high until every enabled request is withdrawn.

A one-bit register address selects one of two views. Address 0 is the read/write enable mask. Address 1 is the read-only status.

Top module: `irq_funnel`

## Requirements
- R1: During and just after reset, `cpu_irq` is low, `bus_oe` is low, the enable mask reads 0 (all maskable sources disabled), and the status reads 0.
- R2: A request line held low appears in its status bit exactly two rising clock edges later. After one edge it is not yet visible.
- R3: Request bits 10..5 are never masked. Any one of them active drives `cpu_irq` high, whatever the mask holds.
- R4: A maskable request (bits 4..0) whose mask bit is 0 leaves `cpu_irq` low. Its status bit still shows it as active.
- R5: A write with `reg_addr`=0 loads `reg_wdata[4:0]` into the mask, where a 1 enables that source. A read at address 0 returns the mask in `reg_rdata[4:0]` and zeros above it.
- R6: A write with `reg_addr`=1 has no effect. The mask and the status are unchanged.
- R7: While `cpu_inta` is high, `bus_oe` is high and `bus_data` is 0xFF (restart-7, vector 0x38). Otherwise `bus_oe` is low and `bus_data` is 0x00.
- R8: An acknowledge does not clear anything. `cpu_irq` stays high through and after `cpu_inta` while an enabled request is held.
- R9: Request inputs are active low: 1 means idle, 0 means request. Bit map: 0 parallel input full, 1 parallel output empty, 2 serial receive full, 3 serial transmit ready, 4 serial transmit empty, 5..6 expansion module, 7..8 user peripherals, 9 power fail, 10 interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 11 | Active-low request lines, bit map in R9 |
| reg_addr | input | 1 | 0 selects the mask, 1 selects the status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Write data for the mask |
| reg_rdata | output | 11 | Read data for the selected register |
| cpu_irq | output | 1 | Level interrupt request to the processor |
| cpu_inta | input | 1 | Interrupt acknowledge from the processor |
| bus_data | output | 8 | Opcode forced onto the data bus |
| bus_oe | output | 1 | Data-bus drive enable |

## Verification
Some behaviour is checked by assertions on every cycle:
- the opcode drive and enable follow the acknowledge input;
- the mask changes only on an address-0 write, and takes the written value;
- the synchronized view lags the pins by two edges;
- the request output is quiet whenever no enabled source is active and high whenever an unmaskable source is active.

Other behaviour can only be shown by the bench's scenarios:
- that the bit positions of the sources are correct;
- that the exact latency is visible through the status read;
- that a write to the status address is harmless;
- that the request persists across and after an acknowledge.

// File: rtl/irq_funnel.sv
module irq_funnel #(
  parameter int          NUM_SRC      = 11,
  parameter int          NUM_MASKABLE = 5,
  parameter logic [7:0]  RST_OPCODE   = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      req_n,
  input  logic                    reg_addr,
  input  logic                    reg_we,
  input  logic [NUM_MASKABLE-1:0] reg_wdata,
  output logic [NUM_SRC-1:0]      reg_rdata,
  output logic                    cpu_irq,
  input  logic                    cpu_inta,
  output logic [7:0]              bus_data,
  output logic                    bus_oe
);

  localparam int NUM_FIXED = NUM_SRC - NUM_MASKABLE;

  logic [NUM_SRC-1:0]      meta_q;
  logic [NUM_SRC-1:0]      live_q;
  logic [NUM_MASKABLE-1:0] mask_q;
  logic [NUM_SRC-1:0]      enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      live_q <= '0;
    end else begin
      meta_q <= ~req_n;
      live_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (reg_we && !reg_addr)
      mask_q <= reg_wdata;
  end

  assign enable    = {{NUM_FIXED{1'b1}}, mask_q};
  assign cpu_irq   = |(live_q & enable);
  assign reg_rdata = reg_addr ? live_q : {{NUM_FIXED{1'b0}}, mask_q};
  assign bus_oe    = cpu_inta;
  assign bus_data  = cpu_inta ? RST_OPCODE : 8'h00;

endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk #(
  parameter int NUM_SRC      = 11,
  parameter int NUM_MASKABLE = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_SRC-1:0]      req_n,
  input logic                    reg_addr,
  input logic                    reg_we,
  input logic [NUM_MASKABLE-1:0] reg_wdata,
  input logic                    cpu_irq,
  input logic                    cpu_inta,
  input logic [7:0]              bus_data,
  input logic                    bus_oe,
  input logic [NUM_SRC-1:0]      live_q,
  input logic [NUM_MASKABLE-1:0] mask_q
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_ack_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_inta |-> (bus_oe && bus_data == 8'hFF));

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_inta |-> (!bus_oe && bus_data == 8'h00));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && !reg_addr) |-> $stable(mask_q));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && !reg_addr) |-> mask_q == $past(reg_wdata));

  p_sync_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> live_q == ~$past(req_n, 2));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((live_q[NUM_MASKABLE-1:0] & mask_q) == '0 &&
     live_q[NUM_SRC-1:NUM_MASKABLE] == '0) |-> !cpu_irq);

  p_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[NUM_SRC-1:NUM_MASKABLE] != '0) |-> cpu_irq);

endmodule

bind irq_funnel irq_funnel_chk #(.NUM_SRC(NUM_SRC), .NUM_MASKABLE(NUM_MASKABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .cpu_irq(cpu_irq), .cpu_inta(cpu_inta),
  .bus_data(bus_data), .bus_oe(bus_oe), .live_q(live_q), .mask_q(mask_q)
);

// File: tb/irq_funnel_tb.sv
module irq_funnel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] req_n = 11'h7FF;
  logic        reg_addr = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic        cpu_irq;
  logic        cpu_inta = 1'b0;
  logic [7:0]  bus_data;
  logic        bus_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_funnel u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq),
    .cpu_inta(cpu_inta), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // {mask[4:0], req_n[10:0], irq, status[10:0]}
  localparam logic [27:0] VEC [11] = '{
    {5'h00, 11'h7FF, 1'b0, 11'h000},
    {5'h00, 11'h7FE, 1'b0, 11'h001},
    {5'h01, 11'h7FE, 1'b1, 11'h001},
    {5'h1E, 11'h7FE, 1'b0, 11'h001},
    {5'h00, 11'h5FF, 1'b1, 11'h200},
    {5'h00, 11'h3FF, 1'b1, 11'h400},
    {5'h10, 11'h7EB, 1'b1, 11'h014},
    {5'h04, 11'h7EF, 1'b0, 11'h010},
    {5'h1F, 11'h000, 1'b1, 11'h7FF},
    {5'h00, 11'h7E0, 1'b0, 11'h01F},
    {5'h00, 11'h7DF, 1'b1, 11'h020}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [10:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] v;
    repeat (3) @(negedge clk);
    chk(!cpu_irq && !bus_oe, "R1 reset irq/oe", {cpu_irq, bus_oe}, 0);
    rd(1'b0, v); chk(v == 0, "R1 reset mask", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 reset status", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_irq && bus_data == 8'h00, "R1 after reset", {cpu_irq, bus_data}, 0);

    for (int i = 0; i < 11; i++) begin
      wr(1'b0, VEC[i][27:23]);
      req_n = VEC[i][22:12];
      repeat (3) @(negedge clk);
      chk(cpu_irq == VEC[i][11], $sformatf("R3/R4 vec%0d irq", i), cpu_irq, VEC[i][11]);
      rd(1'b1, v);
      chk(v == VEC[i][10:0], $sformatf("R9 vec%0d status", i), v, VEC[i][10:0]);
      rd(1'b0, v);
      chk(v == {6'h0, VEC[i][27:23]}, $sformatf("R5 vec%0d mask", i), v, VEC[i][27:23]);
    end

    req_n = 11'h7FF;
    wr(1'b0, 5'h00);
    repeat (3) @(negedge clk);
    reg_addr = 1'b1;
    req_n = 11'h7BF;
    @(negedge clk);
    #1 chk(reg_rdata == 0, "R2 one edge", reg_rdata, 0);
    @(negedge clk);
    #1 chk(reg_rdata == 11'h040, "R2 two edges", reg_rdata, 11'h040);
    req_n = 11'h7FF;
    repeat (3) @(negedge clk);

    wr(1'b0, 5'h0A);
    wr(1'b1, 5'h15);
    rd(1'b0, v); chk(v == 11'h00A, "R6 mask kept", v, 11'h00A);
    rd(1'b1, v); chk(v == 11'h000, "R6 status kept", v, 0);

    chk(!bus_oe && bus_data == 8'h00, "R7 idle bus", {bus_oe, bus_data}, 0);
    req_n = 11'h7F7;
    repeat (3) @(negedge clk);
    chk(cpu_irq, "R8 irq before ack", cpu_irq, 1);
    cpu_inta = 1'b1;
    #1 chk(bus_oe && bus_data == 8'hFF, "R7 ack opcode", {bus_oe, bus_data}, 9'h1FF);
    repeat (2) @(negedge clk);
    chk(cpu_irq, "R8 irq during ack", cpu_irq, 1);
    cpu_inta = 1'b0;
    #1 chk(!bus_oe && bus_data == 8'h00, "R7 ack released", {bus_oe, bus_data}, 0);
    repeat (2) @(negedge clk);
    chk(cpu_irq, "R8 irq after ack", cpu_irq, 1);
    req_n = 11'h7FF;
    repeat (3) @(negedge clk);
    chk(!cpu_irq, "R8 irq drops on release", cpu_irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule